// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar as packed BCD fields: hundredths of a second, seconds, minutes, hours in 24-hour form, day of week, day of month, month, a two-digit year and a one-bit century marker. A prescaler outside the block supplies a one-cycle `tick_i` pulse. Every `PRE_DIV` accepted ticks advance the hundredths field by one step. At the default `PRE_DIV` of 1, this is one step per tick at 100 Hz. Each carry ripples as far as the calendar requires. Month lengths, including February in leap years, are handled inside the block.

The block holds two copies of the time. The running copy always counts. The visible copy on the output ports takes every freshly advanced value in a single cycle, unless `freeze_i` is high. A reader therefore holds `freeze_i` while it gathers several fields, and it never sees a torn value. Counting resumes with no lost time when `freeze_i` is released.

A parallel write port loads one field at a time into both copies. Every write clears the hundredths field and restarts the prescale divider, so the new time starts from a clean second boundary. `halt_i` stops counting entirely.

Top module: `bcd_tod_calendar`

## Requirements
- R1: After reset, both copies read 00:00:00.00, day of week 01, date 01, month 01, year 00 and century 0.
- R2: Each step adds one to hundredths, in BCD, from 00 to 99. Wrapping from 99 to 00 adds one second. Seconds and minutes run 00 to 59, and each wrap carries into the next field. Hours run 00 to 23.
- R3: When the hour wraps from 23 to 00, day of week advances by one, and 07 wraps to 01.
- R4: At midnight the date passes its month's last day and returns to 01, carrying into the month. Months 04, 06, 09 and 11 end on 30. February ends on 29 when the BCD year is divisible by 4, including 00, and on 28 otherwise. All other months end on 31.
- R5: Month 12 wraps to 01 and adds one to the year. Year 99 wraps to 00.
- R6: When the year wraps from 99 to 00, the century bit flips if `cent_en_i` is 1 and holds if it is 0. At no other time does the century bit change except by a write.
- R7: While `halt_i` is 1, ticks are ignored and neither copy changes.
- R8: While `freeze_i` is 1, the outputs hold but the running copy keeps counting. The first step after release shows the running copy's current value.
- R9: A write (`wr_en_i`=1) updates both copies one cycle later. The field written is chosen by `wr_sel_i`: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. For code 3, `wr_data_i[5:0]` holds the hours and `wr_data_i[6]` holds the century bit. Every write sets hundredths to 00 whatever its data and field. A write takes priority over a tick in the same cycle, and that tick is lost.
- R10: A write restarts the prescale divider, so hundredths reads 01 after the `PRE_DIV`-th accepted tick following the write. With the default of 1, this is the first tick.
- R11: On each unfrozen step, every visible field, including the century bit, takes the newly advanced running value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse from the prescaler |
| halt_i | input | 1 | Stops counting while high |
| freeze_i | input | 1 | Holds the visible copy while high |
| cent_en_i | input | 1 | Allows the century bit to flip on year wrap |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Field code of the write |
| wr_data_i | input | 8 | BCD write data |
| hund_o | output | 8 | Hundredths of a second, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours 00-23, BCD |
| dow_o | output | 8 | Day of week 01-07 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00-99, BCD |
| century_o | output | 1 | Century bit |

## Verification
Directed runs load 23:59:59 on the last day of February in leap and non-leap years, in year 00, on a 30-day and a 31-day month, and on 31 December. These runs separate the month-length table, the BCD divisibility test and the year/century carry. The 31 December case is run with the century enable set and with it cleared. Halt, freeze-and-release and write-with-tick patterns show which copy moves, and when. Random mixes of ticks, writes biased toward 59/23/12/99 limits, halts and freezes, drawn from a fixed seed, are compared against a binary-arithmetic model. These mixes catch carry and freeze interactions that the directed cases do not order.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int DIG_W   = 8;
   localparam int N_FIELD = 8;
   localparam int SEL_W   = $clog2(N_FIELD);

   localparam int F_HUND = 0;
   localparam int F_SEC  = 1;
   localparam int F_MIN  = 2;
   localparam int F_HOUR = 3;
   localparam int F_DOW  = 4;
   localparam int F_DATE = 5;
   localparam int F_MON  = 6;
   localparam int F_YEAR = 7;

   typedef logic [DIG_W-1:0] bcd_t;
   typedef logic [N_FIELD-1:0][DIG_W-1:0] tod_vec_t;

   function automatic bcd_t bcd_inc(bcd_t v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by 4 on a BCD pair: even tens with units 0/4/8, odd tens with 2/6
   function automatic logic bcd_leap(bcd_t y);
      if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   function automatic bcd_t month_last_day(bcd_t mon, bcd_t yr);
      case (mon)
         8'h02: return bcd_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default: return 8'h31;
      endcase
   endfunction

   function automatic bcd_t field_first(int f);
      if (f == F_DOW || f == F_DATE || f == F_MON) return 8'h01;
      return 8'h00;
   endfunction

   function automatic bcd_t field_last(int f);
      case (f)
         F_HUND:  return 8'h99;
         F_SEC:   return 8'h59;
         F_MIN:   return 8'h59;
         F_HOUR:  return 8'h23;
         F_DOW:   return 8'h07;
         F_DATE:  return 8'h31;
         F_MON:   return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

   function automatic tod_vec_t tod_reset_vec();
      tod_vec_t v;
      for (int f = 0; f < N_FIELD; f++) v[f] = field_first(f);
      return v;
   endfunction

endpackage

// File: rtl/tod_bcd_step.sv
module tod_bcd_step
   import tod_pkg::*;
#(
   parameter bcd_t FIRST = 8'h00
) (
   input  bcd_t cur_i,
   input  logic en_i,
   input  logic at_last_i,
   output bcd_t nxt_o
);

   always_comb begin
      if (!en_i)          nxt_o = cur_i;
      else if (at_last_i) nxt_o = FIRST;
      else                nxt_o = bcd_inc(cur_i);
   end

endmodule

// File: rtl/tod_advance.sv
module tod_advance
   import tod_pkg::*;
(
   input  tod_vec_t cur_i,
   input  logic     cent_i,
   input  logic     step_i,
   input  logic     cent_en_i,
   output tod_vec_t nxt_o,
   output logic     cent_o
);

   tod_vec_t             last_v;
   logic [N_FIELD-1:0]   at_v;
   logic [N_FIELD-1:0]   en_v;
   logic                 en_sec, en_min, en_hr, en_day, en_mon, en_yr, cent_flip;

   always_comb begin
      for (int f = 0; f < N_FIELD; f++) last_v[f] = field_last(f);
      last_v[F_DATE] = month_last_day(cur_i[F_MON], cur_i[F_YEAR]);
   end

   // at-or-past the limit wraps, so an out-of-range load still recovers
   for (genvar g = 0; g < N_FIELD; g++) begin : g_at
      assign at_v[g] = (cur_i[g] >= last_v[g]);
   end

   assign en_sec    = step_i & at_v[F_HUND];
   assign en_min    = en_sec & at_v[F_SEC];
   assign en_hr     = en_min & at_v[F_MIN];
   assign en_day    = en_hr  & at_v[F_HOUR];
   assign en_mon    = en_day & at_v[F_DATE];
   assign en_yr     = en_mon & at_v[F_MON];
   assign cent_flip = en_yr  & at_v[F_YEAR] & cent_en_i;

   assign en_v = {en_yr, en_mon, en_day, en_day, en_hr, en_min, en_sec, step_i};

   for (genvar g = 0; g < N_FIELD; g++) begin : g_field
      tod_bcd_step #(.FIRST(field_first(g))) u_step (
         .cur_i     (cur_i[g]),
         .en_i      (en_v[g]),
         .at_last_i (at_v[g]),
         .nxt_o     (nxt_o[g])
      );
   end

   assign cent_o = cent_i ^ cent_flip;

endmodule

// File: rtl/tod_prediv.sv
module tod_prediv #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,
   input  logic restart_i,
   output logic step_o
);

   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("tod_prediv: DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take   = tick_i & run_i & ~restart_i;
   assign step_o = take & (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (take)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   // R10
   prediv_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   // R7
   prediv_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bcd_tod_calendar.sv
module bcd_tod_calendar
   import tod_pkg::*;
#(
   parameter int PRE_DIV = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             halt_i,
   input  logic             freeze_i,
   input  logic             cent_en_i,
   input  logic             wr_en_i,
   input  logic [SEL_W-1:0] wr_sel_i,
   input  logic [DIG_W-1:0] wr_data_i,
   output logic [DIG_W-1:0] hund_o,
   output logic [DIG_W-1:0] sec_o,
   output logic [DIG_W-1:0] min_o,
   output logic [DIG_W-1:0] hour_o,
   output logic [DIG_W-1:0] dow_o,
   output logic [DIG_W-1:0] date_o,
   output logic [DIG_W-1:0] month_o,
   output logic [DIG_W-1:0] year_o,
   output logic             century_o
);

   localparam tod_vec_t RST_V = tod_reset_vec();

   if (PRE_DIV < 1) begin : g_bad_prediv
      $error("bcd_tod_calendar: PRE_DIV must be at least 1");
   end

   tod_vec_t int_q, usr_q, adv_v, wr_v;
   logic     int_cent_q, usr_cent_q, adv_cent, wr_cent;
   logic     step;

   // prescale variant: a bare gate at 1, a restartable counter above
   if (PRE_DIV == 1) begin : g_nodiv
      assign step = tick_i & ~halt_i & ~wr_en_i;
   end else begin : g_div
      tod_prediv #(.DIV(PRE_DIV)) u_prediv (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick_i),
         .run_i     (~halt_i),
         .restart_i (wr_en_i),
         .step_o    (step)
      );
   end

   tod_advance u_adv (
      .cur_i     (int_q),
      .cent_i    (int_cent_q),
      .step_i    (step),
      .cent_en_i (cent_en_i),
      .nxt_o     (adv_v),
      .cent_o    (adv_cent)
   );

   always_comb begin
      wr_v            = int_q;
      wr_cent         = int_cent_q;
      wr_v[wr_sel_i]  = wr_data_i;
      if (wr_sel_i == SEL_W'(F_HOUR)) begin
         wr_v[F_HOUR] = {2'b00, wr_data_i[5:0]};
         wr_cent      = wr_data_i[6];
      end
      wr_v[F_HUND]    = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q      <= RST_V;
         usr_q      <= RST_V;
         int_cent_q <= 1'b0;
         usr_cent_q <= 1'b0;
      end else if (wr_en_i) begin
         int_q      <= wr_v;
         usr_q      <= wr_v;
         int_cent_q <= wr_cent;
         usr_cent_q <= wr_cent;
      end else if (step) begin
         int_q      <= adv_v;
         int_cent_q <= adv_cent;
         if (!freeze_i) begin
            usr_q      <= adv_v;
            usr_cent_q <= adv_cent;
         end
      end
   end

   assign hund_o    = usr_q[F_HUND];
   assign sec_o     = usr_q[F_SEC];
   assign min_o     = usr_q[F_MIN];
   assign hour_o    = usr_q[F_HOUR];
   assign dow_o     = usr_q[F_DOW];
   assign date_o    = usr_q[F_DATE];
   assign month_o   = usr_q[F_MON];
   assign year_o    = usr_q[F_YEAR];
   assign century_o = usr_cent_q;

   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_i && !wr_en_i) |=> ($stable(usr_q) && $stable(usr_cent_q)));

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !wr_en_i) |=> ($stable(int_q) && $stable(usr_q)));

   // R9
   wr_hund_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (usr_q[F_HUND] == '0 && int_q[F_HUND] == '0));

   // R6
   cent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !cent_en_i) |=> $stable(int_cent_q));

endmodule

// File: tb/bcd_tod_calendar_tb.sv
module bcd_tod_calendar_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, halt_i = 1'b0, freeze_i = 1'b0, cent_en_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_sel_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] hund_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
   logic       century_o;

   always #4 clk = ~clk;

   bcd_tod_calendar u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_i),
      .freeze_i(freeze_i), .cent_en_i(cent_en_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
      .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
      .century_o(century_o)
   );

   typedef struct {int h; int s; int mi; int hr; int dw; int dt; int mo; int yr; int c;} tm_t;

   tm_t m_int, m_usr;
   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   function automatic logic [7:0] bin2bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int bcd2bin(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int dim(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic tm_t adv(tm_t t, bit cen);
      t.h++;
      if (t.h == 100) begin
         t.h = 0; t.s++;
         if (t.s == 60) begin
            t.s = 0; t.mi++;
            if (t.mi == 60) begin
               t.mi = 0; t.hr++;
               if (t.hr == 24) begin
                  t.hr = 0;
                  t.dw = (t.dw == 7) ? 1 : t.dw + 1;
                  t.dt++;
                  if (t.dt > dim(t.mo, t.yr)) begin
                     t.dt = 1; t.mo++;
                     if (t.mo == 13) begin
                        t.mo = 1; t.yr++;
                        if (t.yr == 100) begin
                           t.yr = 0;
                           if (cen) t.c = 1 - t.c;
                        end
                     end
                  end
               end
            end
         end
      end
      return t;
   endfunction

   function automatic logic [71:0] pack(tm_t t);
      return {7'd0, 1'(t.c), bin2bcd(t.yr), bin2bcd(t.mo), bin2bcd(t.dt), bin2bcd(t.dw),
              bin2bcd(t.hr), bin2bcd(t.mi), bin2bcd(t.s), bin2bcd(t.h)};
   endfunction

   task automatic check(string tag);
      logic [71:0] act, exp;
      act = {7'd0, century_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o, hund_o};
      exp = pack(m_usr);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(bit tk, bit w, int sel, logic [7:0] d, string tag);
      tm_t t;
      @(negedge clk);
      tick_i = tk; wr_en_i = w; wr_sel_i = 3'(sel); wr_data_i = d;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      if (w) begin
         t = m_int; t.h = 0;
         case (sel)
            1: t.s  = bcd2bin(d);
            2: t.mi = bcd2bin(d);
            3: begin t.hr = bcd2bin({2'b00, d[5:0]}); t.c = int'(d[6]); end
            4: t.dw = bcd2bin(d);
            5: t.dt = bcd2bin(d);
            6: t.mo = bcd2bin(d);
            7: t.yr = bcd2bin(d);
            default: ;
         endcase
         m_int = t; m_usr = t;
      end else if (tk && !halt_i) begin
         m_int = adv(m_int, cent_en_i);
         if (!freeze_i) m_usr = m_int;
      end
      check(tag);
   endtask

   task automatic set_all(int hr, int mi, int s, int dw, int dt, int mo, int yr, int c);
      cyc(0, 1, 6, bin2bcd(mo), "R9 write month");
      cyc(0, 1, 7, bin2bcd(yr), "R9 write year");
      cyc(0, 1, 5, bin2bcd(dt), "R9 write date");
      cyc(0, 1, 4, bin2bcd(dw), "R9 write dow");
      cyc(0, 1, 3, {1'b0, 1'(c), bin2bcd(hr)[5:0]}, "R9 write hour");
      cyc(0, 1, 2, bin2bcd(mi), "R9 write min");
      cyc(0, 1, 1, bin2bcd(s), "R9 write sec");
   endtask

   task automatic run_ticks(int n, string tag);
      repeat (n) cyc(1, 0, 0, 8'h00, tag);
   endtask

   function automatic logic [7:0] rand_data(int sel);
      bit lim;
      lim = ($urandom % 2) == 0;
      case (sel)
         1, 2:    return bin2bcd(lim ? 59 : int'($urandom % 60));
         3:       return {1'b0, 1'($urandom % 2), bin2bcd(lim ? 23 : int'($urandom % 24))[5:0]};
         4:       return bin2bcd(1 + int'($urandom % 7));
         5:       return bin2bcd(lim ? 28 : 1 + int'($urandom % 28));
         6:       return bin2bcd(lim ? 12 : 1 + int'($urandom % 12));
         7:       return bin2bcd(lim ? 99 : int'($urandom % 100));
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      m_int = '{0, 0, 0, 0, 1, 1, 1, 0, 0};
      m_usr = m_int;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset");

      run_ticks(12, "R2 R11 basic count");

      // R3 R4: non-leap February, day of week 7 wraps to 1
      set_all(23, 59, 59, 7, 28, 2, 23, 0);
      run_ticks(100, "R3 R4 feb28 nonleap");
      // R4 leap year
      set_all(23, 59, 59, 3, 28, 2, 24, 0);
      run_ticks(100, "R4 feb28 leap");
      set_all(23, 59, 59, 4, 29, 2, 24, 0);
      run_ticks(100, "R4 feb29 leap");
      set_all(23, 59, 59, 2, 29, 2, 0, 1);
      run_ticks(100, "R4 year00 leap");
      set_all(23, 59, 59, 5, 30, 4, 31, 0);
      run_ticks(100, "R4 30-day month");
      set_all(23, 59, 59, 6, 31, 1, 31, 0);
      run_ticks(100, "R4 31-day month");
      set_all(23, 59, 59, 1, 31, 12, 45, 0);
      run_ticks(100, "R5 dec to jan");
      // R5 R6 century flip and hold
      cent_en_i = 1'b1;
      set_all(23, 59, 59, 1, 31, 12, 99, 0);
      run_ticks(100, "R5 R6 century flip");
      cent_en_i = 1'b0;
      set_all(23, 59, 59, 1, 31, 12, 99, 1);
      run_ticks(100, "R6 century hold");

      halt_i = 1'b1;
      run_ticks(5, "R7 halt");
      halt_i = 1'b0;

      freeze_i = 1'b1;
      run_ticks(20, "R8 freeze hold");
      freeze_i = 1'b0;
      run_ticks(1, "R8 R11 release");

      cyc(0, 1, 0, 8'h55, "R9 hund forced zero");
      cyc(1, 1, 2, 8'h33, "R9 write wins over tick");
      cyc(1, 0, 0, 8'h00, "R10 divider restart");

      for (int i = 0; i < 4000; i++) begin
         int sel;
         halt_i    = ($urandom % 16) == 0;
         freeze_i  = ($urandom % 4) == 0;
         cent_en_i = 1'($urandom % 2);
         if (($urandom % 20) == 0) begin
            sel = int'($urandom % 8);
            cyc(0, 1, sel, rand_data(sel), "R9 random write");
         end else begin
            cyc(1, 0, 0, 8'h00, "R2 R8 random tick");
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule